// File: doc/BRIEF.md
# Multi-channel interrupt status controller

This block gathers the interrupt events of a multi-channel serial interface and presents them to a host through a small 16-bit register bus. Each channel reports four event sources as synchronous level inputs: a sync character has been seen, the receive FIFO holds data, the receive FIFO is nearly full, and the transmit FIFO has drained. The host decides which sources may interrupt by writing an enable register. It reads a status register to find which events fired and writes ones to that register to acknowledge them.

Each enabled source latches a sticky flag on the rising edge of its level. A disabled source has no flag, and its status bit shows the live level of the input instead. This lets software poll a source without taking interrupts from it. A single level request, the OR of all enabled latched flags, goes to the bus interrupter. The register bus is plain, with no back-pressure. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` and always valid.

Top module: `irq_status_ctrl`

## Requirements
- R1: Address 0 holds the enable register, which is read/write. Channel c owns bits 4c..4c+3 in both the enable and the status register, in this order: bit 4c = sync detected, 4c+1 = receive FIFO not empty, 4c+2 = receive FIFO almost full, 4c+3 = transmit FIFO empty.
- R2: A rising edge on the level of an enabled source sets its latched flag. Status, read at address 1, shows the flag as 1 from the clock edge that follows the first cycle in which the level is high.
- R3: A latched flag stays set until the host clears it. A source that is still high after the clear does not set the flag again; only a new rising edge does.
- R4: Writing a 1 to a status bit clears its latched flag. Writing a 0 leaves the flag unchanged.
- R5: For a disabled source, the status bit reads the present level of the input, combinationally.
- R6: A rising edge and a write-one-to-clear of the same bit in the same cycle leave the flag set.
- R7: Writing 0 to an enable bit discards that source's latched flag. Turning on an enable while the source is already high does not latch an event.
- R8: `irq_req` is high exactly while at least one enabled source has its flag latched. It changes in the same cycle as the status read.
- R9: Bits above 4*NUM_CH in both registers read 0 and ignore writes. Addresses 2 and 3 read 0 and ignore writes.
- R10: A synchronous reset clears every enable and every latched flag and drops `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Register address (0 enable, 1 status) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| ev_sync | input | NUM_CH | Per-channel sync detected level |
| ev_rx_ne | input | NUM_CH | Per-channel receive FIFO not empty level |
| ev_rx_af | input | NUM_CH | Per-channel receive FIFO almost full level |
| ev_tx_mt | input | NUM_CH | Per-channel transmit FIFO empty level |
| irq_req | output | 1 | Level interrupt request toward the bus interrupter |

## Verification
The bench builds the block with NUM_CH = 3, DATA_W = 16 and ADDR_W = 2. This leaves the top four bits of each register unassigned, so the checks on reserved bits become observable; they would be empty at the default of four channels. The 12 live bits still cover sources in the first, middle and last channel. All four source kinds are driven through their own ports, so the field layout is checked through the pins. Enable, clear and edge events are timed against each other to reach the same-cycle set/clear and enable/disable corners.

// File: rtl/isc_pkg.sv
package isc_pkg;
  // Sources per channel and their bit order inside a channel's nibble.
  localparam int SRC_PER_CH = 4;

  typedef enum int {
    SRC_SYNC   = 0,
    SRC_RX_NE  = 1,
    SRC_RX_AF  = 2,
    SRC_TX_MT  = 3
  } src_idx_e;

  // Register addresses on the host bus.
  localparam int ADDR_EN   = 0;
  localparam int ADDR_STAT = 1;
endpackage

// File: rtl/isc_channel.sv
// One channel's group of event sources: edge detect, sticky flags, enables.
module isc_channel
  import isc_pkg::*;
#(
  parameter int W = SRC_PER_CH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic         en_wr,
  input  logic [W-1:0] en_wdata,
  input  logic [W-1:0] clr,
  output logic [W-1:0] en_q,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] stat,
  output logic         pend
);
  logic [W-1:0] src_q;
  logic [W-1:0] rise;
  logic [W-1:0] en_next;
  logic [W-1:0] lat_next;

  // Edge history follows the input level every cycle.
  always_ff @(posedge clk) begin
    src_q <= src;
  end

  assign rise    = src & ~src_q;
  assign en_next = en_wr ? en_wdata : en_q;

  // Per bit: a disable wins, then a set, then a clear.
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      if (!en_next[b])
        lat_next[b] = 1'b0;
      else if (rise[b] && en_q[b])
        lat_next[b] = 1'b1;
      else if (clr[b])
        lat_next[b] = 1'b0;
      else
        lat_next[b] = lat_q[b];
    end

    assign stat[b] = en_q[b] ? lat_q[b] : src[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      lat_q <= '0;
    end else begin
      en_q  <= en_next;
      lat_q <= lat_next;
    end
  end

  assign pend = |(lat_q & en_q);
endmodule

// File: rtl/isc_regif.sv
// Register bus decode: write strobes out, read mux in.
module isc_regif
  import isc_pkg::*;
#(
  parameter int NS     = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NS-1:0]     en_all,
  input  logic [NS-1:0]     stat_all,
  output logic              en_wr,
  output logic [NS-1:0]     en_wdata,
  output logic [NS-1:0]     clr_all,
  output logic [DATA_W-1:0] bus_rdata
);
  logic sel_en;
  logic sel_stat;

  assign sel_en   = (bus_addr == ADDR_W'(ADDR_EN));
  assign sel_stat = (bus_addr == ADDR_W'(ADDR_STAT));

  assign en_wr    = bus_wr && sel_en;
  assign en_wdata = bus_wdata[NS-1:0];
  assign clr_all  = (bus_wr && sel_stat) ? bus_wdata[NS-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    if (sel_en)
      bus_rdata[NS-1:0] = en_all;
    else if (sel_stat)
      bus_rdata[NS-1:0] = stat_all;
  end

  // Bits above the mapped sources are reserved and dropped.
  if (DATA_W > NS) begin : g_resv
    logic unused_wbits;
    assign unused_wbits = ^bus_wdata[DATA_W-1:NS];
  end
endmodule

// File: rtl/isc_irq_merge.sv
// Folds per-channel pending lines into the single interrupt request.
module isc_irq_merge #(
  parameter int N = 4
) (
  input  logic [N-1:0] pend,
  output logic         irq
);
  assign irq = |pend;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import isc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] ev_sync,
  input  logic [NUM_CH-1:0] ev_rx_ne,
  input  logic [NUM_CH-1:0] ev_rx_af,
  input  logic [NUM_CH-1:0] ev_tx_mt,
  output logic              irq_req
);
  localparam int NS = NUM_CH * SRC_PER_CH;

  logic [NS-1:0]     src_all;
  logic [NS-1:0]     en_all;
  logic [NS-1:0]     lat_all;
  logic [NS-1:0]     stat_all;
  logic [NS-1:0]     en_wdata;
  logic [NS-1:0]     clr_all;
  logic              en_wr;
  logic [NUM_CH-1:0] pend;

  isc_regif #(
    .NS(NS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regif (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .en_all   (en_all),
    .stat_all (stat_all),
    .en_wr    (en_wr),
    .en_wdata (en_wdata),
    .clr_all  (clr_all),
    .bus_rdata(bus_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int LO = c * SRC_PER_CH;

    assign src_all[LO + SRC_SYNC]  = ev_sync[c];
    assign src_all[LO + SRC_RX_NE] = ev_rx_ne[c];
    assign src_all[LO + SRC_RX_AF] = ev_rx_af[c];
    assign src_all[LO + SRC_TX_MT] = ev_tx_mt[c];

    isc_channel #(.W(SRC_PER_CH)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .src     (src_all[LO +: SRC_PER_CH]),
      .en_wr   (en_wr),
      .en_wdata(en_wdata[LO +: SRC_PER_CH]),
      .clr     (clr_all[LO +: SRC_PER_CH]),
      .en_q    (en_all[LO +: SRC_PER_CH]),
      .lat_q   (lat_all[LO +: SRC_PER_CH]),
      .stat    (stat_all[LO +: SRC_PER_CH]),
      .pend    (pend[c])
    );
  end

  isc_irq_merge #(.N(NUM_CH)) u_merge (
    .pend(pend),
    .irq (irq_req)
  );
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
  import isc_pkg::*;
#(
  parameter int NS     = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NS-1:0]     wdata_lo,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NS-1:0]     src_all,
  input logic [NS-1:0]     en_all,
  input logic [NS-1:0]     lat_all,
  input logic              irq_req
);
  logic [NS-1:0] src_d;
  logic [NS-1:0] rise_c;
  logic [NS-1:0] clr_c;
  logic [NS-1:0] en_next_c;
  logic [NS-1:0] set_c;

  always_ff @(posedge clk) src_d <= src_all;

  assign rise_c    = src_all & ~src_d;
  assign clr_c     = (bus_wr && bus_addr == ADDR_W'(ADDR_STAT)) ? wdata_lo : '0;
  assign en_next_c = (bus_wr && bus_addr == ADDR_W'(ADDR_EN)) ? wdata_lo : en_all;
  assign set_c     = rise_c & en_all & en_next_c;

  // R2
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((lat_all & $past(set_c)) == $past(set_c)));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((lat_all & ~$past(lat_all) & ~$past(rise_c & en_all)) == '0));

  // R4
  w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((lat_all & $past(clr_c & ~rise_c)) == '0));

  // R5
  live_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(ADDR_STAT)) |-> ((bus_rdata[NS-1:0] & ~en_all) == (src_all & ~en_all)));

  // R7
  flag_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    ((lat_all & ~en_all) == '0));

  // R8
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req == ((lat_all & en_all) != '0));

  // R9
  unmapped_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != ADDR_W'(ADDR_EN) && bus_addr != ADDR_W'(ADDR_STAT)) |-> (bus_rdata == '0));

  // R10
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (en_all == '0 && lat_all == '0 && !irq_req));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
  .NS(NUM_CH * isc_pkg::SRC_PER_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .wdata_lo (bus_wdata[NUM_CH*isc_pkg::SRC_PER_CH-1:0]),
  .bus_rdata(bus_rdata),
  .src_all  (src_all),
  .en_all   (en_all),
  .lat_all  (lat_all),
  .irq_req  (irq_req)
);

// File: tb/irq_status_ctrl_bench.sv
`timescale 1ns/1ps
module irq_status_ctrl_bench;
  localparam int TB_CH = 3;
  localparam int NSB   = TB_CH * 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [TB_CH-1:0] ev_sync = '0, ev_rx_ne = '0, ev_rx_af = '0, ev_tx_mt = '0;
  logic        irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_status_ctrl #(.NUM_CH(TB_CH), .DATA_W(16), .ADDR_W(2)) u_irq_status_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_sync(ev_sync),
    .ev_rx_ne(ev_rx_ne), .ev_rx_af(ev_rx_af), .ev_tx_mt(ev_tx_mt),
    .irq_req(irq_req)
  );

  typedef struct packed {
    logic [11:0] src;
    logic        wr;
    logic [1:0]  addr;
    logic [15:0] wdata;
    logic [15:0] exp_st;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{12'h000, 1'b1, 2'd0, 16'h0FFF, 16'h0000, 1'b0, 4'd1},  // R1 enable all
    '{12'h001, 1'b0, 2'd0, 16'h0000, 16'h0001, 1'b1, 4'd2},  // R2 ch0 sync edge
    '{12'h000, 1'b0, 2'd0, 16'h0000, 16'h0001, 1'b1, 4'd3},  // R3 sticky
    '{12'h000, 1'b1, 2'd1, 16'h0001, 16'h0000, 1'b0, 4'd4},  // R4 clear
    '{12'h010, 1'b0, 2'd0, 16'h0000, 16'h0010, 1'b1, 4'd2},  // R2 ch1 sync
    '{12'h010, 1'b1, 2'd1, 16'h0010, 16'h0000, 1'b0, 4'd3},  // R3 held high, no re-arm
    '{12'h000, 1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0, 4'd3},  // R3
    '{12'h010, 1'b0, 2'd0, 16'h0000, 16'h0010, 1'b1, 4'd3},  // R3 new edge re-arms
    '{12'h010, 1'b1, 2'd1, 16'h0000, 16'h0010, 1'b1, 4'd4},  // R4 zero write no effect
    '{12'h010, 1'b1, 2'd0, 16'h0FEF, 16'h0010, 1'b0, 4'd7},  // R7 disable drops flag, live 1
    '{12'h000, 1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0, 4'd5},  // R5 live 0
    '{12'h800, 1'b1, 2'd1, 16'h0800, 16'h0800, 1'b1, 4'd6},  // R6 set beats clear
    '{12'h000, 1'b1, 2'd0, 16'h0000, 16'h0000, 1'b0, 4'd8},  // R8 all disabled
    '{12'h0A5, 1'b0, 2'd0, 16'h0000, 16'h00A5, 1'b0, 4'd5},  // R5 live pattern
    '{12'h0A5, 1'b1, 2'd0, 16'h0FFF, 16'h0000, 1'b0, 4'd7},  // R7 enable while high
    '{12'h000, 1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0, 4'd7},  // R7
    '{12'h0A5, 1'b0, 2'd0, 16'h0000, 16'h00A5, 1'b1, 4'd2},  // R2 several channels
    '{12'h000, 1'b1, 2'd1, 16'h0005, 16'h00A0, 1'b1, 4'd8},  // R8 partial clear keeps irq
    '{12'h000, 1'b1, 2'd1, 16'h00A0, 16'h0000, 1'b0, 4'd8}   // R8 last clear drops irq
  };

  task automatic set_src(input logic [11:0] s);
    for (int c = 0; c < TB_CH; c++) begin
      ev_sync[c]  = s[4*c];
      ev_rx_ne[c] = s[4*c+1];
      ev_rx_af[c] = s[4*c+2];
      ev_tx_mt[c] = s[4*c+3];
    end
  endtask

  task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [15:0] rd;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R10 reset state
    bus_read(2'd0, rd); check(10, "enable after reset", rd, 16'h0000);
    bus_read(2'd1, rd); check(10, "status after reset", rd, 16'h0000);
    check(10, "irq after reset", {15'h0, irq_req}, 16'h0000);

    // R1 enable readback
    bus_write(2'd0, 16'h0123);
    bus_read(2'd0, rd); check(1, "enable readback", rd, 16'h0123);

    // R9 reserved bits and addresses
    bus_write(2'd0, 16'hFFFF);
    bus_read(2'd0, rd); check(9, "reserved enable bits", rd, 16'h0FFF);
    bus_read(2'd2, rd); check(9, "address 2 reads zero", rd, 16'h0000);
    bus_write(2'd3, 16'h0000);
    bus_read(2'd3, rd); check(9, "address 3 reads zero", rd, 16'h0000);
    bus_read(2'd0, rd); check(9, "address 3 write ignored", rd, 16'h0FFF);
    bus_write(2'd0, 16'h0000);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      set_src(TBL[i].src);
      bus_wr = TBL[i].wr; bus_addr = TBL[i].addr; bus_wdata = TBL[i].wdata;
      @(posedge clk);
      #1 bus_wr = 1'b0; bus_addr = 2'd1;
      #1;
      check(int'(TBL[i].req), $sformatf("row %0d status", i), bus_rdata, TBL[i].exp_st);
      check(8, $sformatf("row %0d irq", i), {15'h0, irq_req}, {15'h0, TBL[i].exp_irq});
    end

    // R1 layout: channel 2 almost-full sits at bit 10
    @(negedge clk); set_src(12'h400);
    bus_read(2'd1, rd); check(1, "ch2 almost-full bit position", rd, 16'h0400);
    @(negedge clk); set_src(12'h000);
    bus_write(2'd1, 16'h0400);

    // R10 reset mid-run with a latched flag and source held high
    @(negedge clk); set_src(12'h002);
    @(posedge clk); #1;
    check(2, "ch0 rx-not-empty irq", {15'h0, irq_req}, 16'h0001);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    check(10, "irq after mid reset", {15'h0, irq_req}, 16'h0000);
    bus_read(2'd0, rd); check(10, "enable after mid reset", rd, 16'h0000);
    bus_read(2'd1, rd); check(10, "status live after mid reset", rd, 16'h0002);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule